// File: doc/BRIEF.md
# Byte-Serial Synchronous Transmitter with Sync-Fill Idle

This block serialises host bytes onto a single synchronous data line. The host places one byte at a time into a one-entry holding buffer. At each character boundary the block moves that byte into a shift register and sends it out least-significant bit first. It sends one bit per pulse of an external bit-clock enable. Each transmitted data bit also passes through a 16-bit CRC generator. When a message ends, the CRC can be appended automatically.

When no byte is waiting and the transmitter is enabled, the line is filled with sync characters. A mode input picks either one repeated sync character or an alternating pair. While the transmitter is disabled the line rests at mark (high). Data can only start on the boundary of a sync character, so the receiver always sees whole characters.

Top module: `sync_tx`

## Requirements
- R1: While `tx_enable` is low, `txd` is 1. The line returns to 1 on the clock after `tx_enable` falls, even in the middle of a character.
- R2: When enabled with `dual_sync`=0 and an empty buffer, the line repeats `sync_a` as whole 8-bit characters. The first character begins on the first bit tick after enabling.
- R3: With `dual_sync`=1, the fill pattern alternates `sync_a`, `sync_b`, `sync_a`, ..., always starting with `sync_a` after enabling or after a message.
- R4: A byte written during a sync character is not sent until that sync character has been completely shifted out. After enabling, at least one sync character always precedes data.
- R5: Characters leave least-significant bit first. The line advances one bit only on a clock where `bit_en` and `tx_enable` are both high, and otherwise holds its value.
- R6: `buf_empty` is 1 after reset. It goes to 0 on the clock after an accepted write. It returns to 1 only on the bit tick at which the buffered byte is loaded into the shift register.
- R7: The CRC covers data-character bits only (sync bits are excluded), each bit in the order it is sent. The shift-left update uses polynomial 0x8005 when `crc_sel`=1 and 0x1021 when `crc_sel`=0. A `crc_reset` pulse presets the generator to 0x0000 when `crc_sel`=1 and to 0xFFFF when `crc_sel`=0.
- R8: The CRC is appended when `crc_send_en`=1 and the buffer is empty at the end of a data character. It is sent as 16 bits, most-significant bit first, and inverted when `crc_sel`=0. The sync fill then resumes with `sync_a`.
- R9: With `crc_send_en`=0, a data character followed by an empty buffer is followed directly by sync fill.
- R10: A write while `buf_empty` is 0 is ignored; the held byte is not replaced.
- R11: A byte written before the end of the current data character follows it with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-clock bit-time enable |
| tx_enable | input | 1 | Transmitter enable; low forces mark |
| dual_sync | input | 1 | 1 = alternating sync pair, 0 = single sync |
| crc_sel | input | 1 | 1 = CRC-16 (0x8005), 0 = CCITT (0x1021) |
| crc_send_en | input | 1 | Append CRC when a message ends |
| crc_reset | input | 1 | Preset the CRC generator |
| sync_a | input | 8 | First (or only) sync character |
| sync_b | input | 8 | Second sync character |
| wr_valid | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to transmit |
| buf_empty | output | 1 | Holding buffer can accept a byte |
| txd | output | 1 | Serial data line |

## Verification
The bench builds the block with its default 8-bit character width, which gives the 16-bit CRC its own 16-bit shift slot. This makes the two character lengths and their boundaries observable on the line. The bit enable is pulsed every other clock, so the hold between ticks is visible. Writes can land in the middle of a sync character, exactly at a boundary, or while the buffer is full. Both CRC polynomials are run over two-byte messages, which reaches the inverted and the non-inverted appended CRC.

// File: rtl/sync_tx_pkg.sv
package sync_tx_pkg;
  typedef enum logic [1:0] {
    TXM_MARK = 2'd0,
    TXM_SYNC = 2'd1,
    TXM_DATA = 2'd2,
    TXM_CRC  = 2'd3
  } txm_e;

  localparam int unsigned CRC_W = 16;
  localparam logic [CRC_W-1:0] POLY_C16   = 16'h8005;
  localparam logic [CRC_W-1:0] POLY_CCITT = 16'h1021;
endpackage

// File: rtl/sync_tx_crc.sv
module sync_tx_crc
  import sync_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sel,
  input  logic             upd,
  input  logic             din,
  output logic [CRC_W-1:0] crc_q,
  output logic [CRC_W-1:0] crc_d
);
  logic fb;

  always_comb begin
    fb    = crc_q[CRC_W-1] ^ din;
    crc_d = crc_q;
    if (clr) begin
      crc_d = sel ? '0 : '1;
    end else if (upd) begin
      crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? (sel ? POLY_C16 : POLY_CCITT) : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end
endmodule

// File: rtl/sync_tx_shifter.sv
module sync_tx_shifter #(
  parameter int unsigned SH_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [SH_W-1:0] load_val,
  input  logic            shift,
  output logic            bit_out
);
  logic [SH_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)       sh_d = load_val;
    else if (shift) sh_d = {1'b0, sh_q[SH_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign bit_out = sh_q[0];
endmodule

// File: rtl/sync_tx_seq.sv
module sync_tx_seq
  import sync_tx_pkg::*;
#(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned SH_W   = 16,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              tx_enable,
  input  logic              dual_sync,
  input  logic              crc_sel,
  input  logic              crc_send_en,
  input  logic [CHAR_W-1:0] sync_a,
  input  logic [CHAR_W-1:0] sync_b,
  input  logic              wr_valid,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic [CRC_W-1:0]  crc_d,
  output logic              load,
  output logic [SH_W-1:0]   load_val,
  output logic              shift,
  output logic              crc_upd,
  output txm_e              mode,
  output logic              buf_empty
);
  localparam logic [CNT_W-1:0] LAST_CHAR = CNT_W'(CHAR_W - 1);
  localparam logic [CNT_W-1:0] LAST_CRC  = CNT_W'(CRC_W - 1);

  txm_e              mode_q, mode_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              idx_q, idx_n;
  logic              full_q, full_n;
  logic [CHAR_W-1:0] buf_q, buf_n;

  logic              tick, boundary, take_data, take_crc;
  logic [CNT_W-1:0]  last_idx;
  logic [CRC_W-1:0]  crc_out, crc_rev;

  always_comb begin
    crc_out = crc_sel ? crc_d : ~crc_d;
    for (int i = 0; i < int'(CRC_W); i++) crc_rev[i] = crc_out[CRC_W-1-i];
  end

  always_comb begin
    tick      = bit_en & tx_enable;
    last_idx  = (mode_q == TXM_CRC) ? LAST_CRC : LAST_CHAR;
    boundary  = (mode_q == TXM_MARK) | (cnt_q == last_idx);
    load      = tick & boundary;
    shift     = tick & ~boundary;
    crc_upd   = tick & (mode_q == TXM_DATA);
    take_data = full_q & (mode_q != TXM_MARK);
    take_crc  = ~take_data & (mode_q == TXM_DATA) & crc_send_en;

    if (take_data)      load_val = SH_W'(buf_q);
    else if (take_crc)  load_val = SH_W'(crc_rev);
    else if (dual_sync && idx_q) load_val = SH_W'(sync_b);
    else                load_val = SH_W'(sync_a);

    mode_n = mode_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    if (!tx_enable) begin
      mode_n = TXM_MARK;
      cnt_n  = '0;
      idx_n  = 1'b0;
    end else if (tick) begin
      if (boundary) begin
        cnt_n = '0;
        if (take_data) begin
          mode_n = TXM_DATA;
          idx_n  = 1'b0;
        end else if (take_crc) begin
          mode_n = TXM_CRC;
          idx_n  = 1'b0;
        end else begin
          mode_n = TXM_SYNC;
          idx_n  = dual_sync & ~idx_q;
        end
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end

    full_n = full_q;
    buf_n  = buf_q;
    if (load && take_data) full_n = 1'b0;
    if (wr_valid && !full_q) begin
      full_n = 1'b1;
      buf_n  = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= TXM_MARK;
      cnt_q  <= '0;
      idx_q  <= 1'b0;
      full_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      mode_q <= mode_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      full_q <= full_n;
      buf_q  <= buf_n;
    end
  end

  assign mode      = mode_q;
  assign buf_empty = ~full_q;
endmodule

// File: rtl/sync_tx.sv
module sync_tx
  import sync_tx_pkg::*;
#(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              tx_enable,
  input  logic              dual_sync,
  input  logic              crc_sel,
  input  logic              crc_send_en,
  input  logic              crc_reset,
  input  logic [CHAR_W-1:0] sync_a,
  input  logic [CHAR_W-1:0] sync_b,
  input  logic              wr_valid,
  input  logic [CHAR_W-1:0] wr_data,
  output logic              buf_empty,
  output logic              txd
);
  localparam int unsigned SH_W  = (CHAR_W > CRC_W) ? CHAR_W : CRC_W;
  localparam int unsigned CNT_W = $clog2(SH_W);

  logic             load, shift, crc_upd, sh_bit;
  logic [SH_W-1:0]  load_val;
  logic [CRC_W-1:0] crc_q, crc_d;
  txm_e             mode;

  sync_tx_seq #(.CHAR_W(CHAR_W), .SH_W(SH_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_enable(tx_enable),
    .dual_sync(dual_sync), .crc_sel(crc_sel), .crc_send_en(crc_send_en),
    .sync_a(sync_a), .sync_b(sync_b), .wr_valid(wr_valid), .wr_data(wr_data),
    .crc_d(crc_d), .load(load), .load_val(load_val), .shift(shift),
    .crc_upd(crc_upd), .mode(mode), .buf_empty(buf_empty)
  );

  sync_tx_shifter #(.SH_W(SH_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .shift(shift), .bit_out(sh_bit)
  );

  sync_tx_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_reset), .sel(crc_sel),
    .upd(crc_upd), .din(sh_bit), .crc_q(crc_q), .crc_d(crc_d)
  );

  assign txd = (mode == TXM_MARK) ? 1'b1 : sh_bit;
endmodule

// File: rtl/sync_tx_chk.sv
module sync_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic tx_enable,
  input logic wr_valid,
  input logic buf_empty,
  input logic txd
);
  AST_MARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |=> txd); // R1
  AST_TXD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_enable && !bit_en) |=> $stable(txd)); // R5
  AST_EMPTY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> $past(bit_en && tx_enable)); // R6
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_empty && wr_valid) |=> !buf_empty); // R6
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_empty && !(bit_en && tx_enable)) |=> !buf_empty); // R10
endmodule

bind sync_tx sync_tx_chk u_chk (.*);

// File: tb/sync_tx_bench.sv
module sync_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n, bit_en, tx_enable, dual_sync, crc_sel, crc_send_en, crc_reset;
  logic [7:0] sync_a, sync_b, wr_data;
  logic       wr_valid, buf_empty, txd;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  sync_tx u_sync_tx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_enable(tx_enable),
    .dual_sync(dual_sync), .crc_sel(crc_sel), .crc_send_en(crc_send_en),
    .crc_reset(crc_reset), .sync_a(sync_a), .sync_b(sync_b),
    .wr_valid(wr_valid), .wr_data(wr_data), .buf_empty(buf_empty), .txd(txd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(output logic b);
    @(negedge clk) bit_en = 1'b1;
    @(negedge clk) bit_en = 1'b0;
    b = txd;
  endtask

  task automatic exp_char(input logic [15:0] v, input int n, input string req);
    logic [15:0] got = '0;
    logic [15:0] mask = 16'((32'd1 << n) - 1);
    logic b;
    for (int i = 0; i < n; i++) begin
      tick(b);
      got[i] = b;
    end
    chk((got & mask) == (v & mask), req, int'(got), int'(v & mask));
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk) begin wr_valid = 1'b1; wr_data = d; end
    @(negedge clk) wr_valid = 1'b0;
  endtask

  task automatic restart(input logic dual, input logic sel, input logic send);
    @(negedge clk) tx_enable = 1'b0;
    dual_sync = dual; crc_sel = sel; crc_send_en = send;
    @(negedge clk) tx_enable = 1'b1;
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b, input logic sel);
    logic [15:0] p = sel ? 16'h8005 : 16'h1021;
    return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? p : 16'h0000);
  endfunction

  function automatic logic [15:0] crc_bytes(input logic [7:0] d0, input logic [7:0] d1, input logic sel);
    logic [15:0] c = sel ? 16'h0000 : 16'hFFFF;
    for (int i = 0; i < 8; i++) c = crc_step(c, d0[i], sel);
    for (int i = 0; i < 8; i++) c = crc_step(c, d1[i], sel);
    if (!sel) c = ~c;
    return c;
  endfunction

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(txd == 1'b1, "R1 reset line", int'(txd), 1);
    chk(buf_empty == 1'b1, "R6 reset empty", int'(buf_empty), 1);
  endtask

  task automatic t_disabled();
    logic b;
    bit   all_one = 1'b1;
    tx_enable = 1'b0;
    for (int i = 0; i < 10; i++) begin
      tick(b);
      if (b !== 1'b1) all_one = 1'b0;
    end
    chk(all_one, "R1 mark while disabled", int'(all_one), 1);
  endtask

  task automatic t_single();
    logic b, held;
    restart(1'b0, 1'b0, 1'b0);
    exp_char({8'h0, sync_a}, 8, "R2 sync 1");
    exp_char({8'h0, sync_a}, 8, "R2 sync 2");
    tick(b);
    held = b;
    repeat (3) @(negedge clk);
    chk(txd == held, "R5 hold without tick", int'(txd), int'(held));
    exp_char({8'h0, sync_a >> 1}, 7, "R2 R5 rest of sync 3");
  endtask

  task automatic t_dual();
    restart(1'b1, 1'b0, 1'b0);
    exp_char({8'h0, sync_a}, 8, "R3 first A");
    exp_char({8'h0, sync_b}, 8, "R3 then B");
    exp_char({8'h0, sync_a}, 8, "R3 A again");
    exp_char({8'h0, sync_b}, 8, "R3 B again");
  endtask

  task automatic t_data_mid();
    logic [7:0] got = '0;
    logic b;
    restart(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin tick(b); got[i] = b; end
    wr(8'hC6);
    chk(buf_empty == 1'b0, "R6 write clears empty", int'(buf_empty), 0);
    for (int i = 3; i < 8; i++) begin tick(b); got[i] = b; end
    chk(got == sync_a, "R4 sync finishes first", int'(got), int'(sync_a));
    chk(buf_empty == 1'b0, "R4 R6 still held at last sync bit", int'(buf_empty), 0);
    exp_char(16'h00C6, 8, "R5 data lsb first");
    chk(buf_empty == 1'b1, "R6 empty after load", int'(buf_empty), 1);
    exp_char({8'h0, sync_a}, 8, "R9 sync after data without crc");
  endtask

  task automatic t_crc(input logic sel, input logic [7:0] d0, input logic [7:0] d1);
    logic [15:0] c;
    restart(1'b0, sel, 1'b1);
    exp_char({8'h0, sync_a}, 8, "R4 preamble before message");
    @(negedge clk) crc_reset = 1'b1;
    @(negedge clk) crc_reset = 1'b0;
    wr(d0);
    exp_char({8'h0, d0}, 8, "R11 first byte");
    wr(d1);
    exp_char({8'h0, d1}, 8, "R11 second byte no gap");
    c = crc_bytes(d0, d1, sel);
    exp_char(rev16(c), 16, sel ? "R7 R8 crc16 msb first" : "R7 R8 ccitt inverted");
    exp_char({8'h0, sync_a}, 8, "R8 sync resumes");
  endtask

  task automatic t_full_ignore();
    restart(1'b0, 1'b0, 1'b0);
    wr(8'h3C);
    wr(8'hA5);
    exp_char({8'h0, sync_a}, 8, "R10 sync first");
    exp_char(16'h003C, 8, "R10 held byte kept");
    exp_char({8'h0, sync_a}, 8, "R10 second write dropped");
  endtask

  task automatic t_disable_mid();
    logic b;
    restart(1'b0, 1'b0, 1'b0);
    repeat (3) tick(b);
    @(negedge clk) tx_enable = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R1 mark after mid-char disable", int'(txd), 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; tx_enable = 1'b0; dual_sync = 1'b0;
    crc_sel = 1'b0; crc_send_en = 1'b0; crc_reset = 1'b0;
    sync_a = 8'h16; sync_b = 8'h7E; wr_valid = 1'b0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_single();
    t_dual();
    t_data_mid();
    t_crc(1'b1, 8'h31, 8'hA2);
    t_crc(1'b0, 8'h5B, 8'h0F);
    t_full_ignore();
    t_disable_mid();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule